// File: doc/BRIEF.md
# I2C Master Receive FIFO Controller

This block is the receive data path of an I2C master running with a byte queue. A byte-level bit engine presents each byte it has clocked in from the bus. The block stores the byte and tells the engine, in the same cycle, whether to answer it with ACK or NACK. Software drains the queue through a pop-on-read data port. It watches an occupancy count and a sticky threshold flag.

Software programs a threshold of at most the queue depth, normally the smaller of the bytes still expected and the depth. When the stored count reaches that threshold, or the queue is full, the block holds SCL low so the remote device cannot send more. Draining the queue, or raising the threshold, releases the clock. A LAST control bit makes the byte that completes a threshold group receive a NACK, which ends a read. When the queue mode is switched off, the block behaves as a one-byte data register with a fixed threshold of one.

Top module: `i2c_rx_fifo_ctrl`

## Requirements
- R1: After reset the occupancy is 0, SCL is not held, `rx_ready` is 1, both flags are 0 and the programmed threshold reads 0.
- R2: In queue mode up to DEPTH (32) bytes are stored and read back on `rd_data` in arrival order; `occupancy` (0..DEPTH) equals the stored byte count.
- R3: A cycle with `rd_en` high and occupancy non-zero removes the head byte, and the occupancy is one lower after that clock edge; `rd_en` on an empty queue changes nothing.
- R4: `rx_ready` is 0 whenever the queue is at capacity, and a byte offered then is not stored.
- R5: `thr_status` sets on the edge where the count moves from below a non-zero threshold to equal to it (queue mode only); a 1 on `thr_status_clr` clears it, and a new set wins over a clear in the same cycle.
- R6: `scl_hold` is 1 in the cycle after one in which the count is at capacity, or is at or above a non-zero threshold in queue mode.
- R7: `scl_hold` returns to 0 one cycle after the count drops below the threshold or the threshold is written above the count.
- R8: `rx_nack` is 1 for an offered byte exactly when LAST is set and that byte would bring the count to the effective threshold (the programmed value in queue mode, 1 in single-byte mode).
- R9: `fifo_clr` empties the queue at the next edge and takes priority over a push or pop in the same cycle.
- R10: `rxf_flag` sets on the edge where the count reaches capacity from below, and a 1 on `rxf_flag_clr` clears it.
- R11: With `fifo_en` low, the capacity is one byte: after one byte `rx_ready` is 0, SCL is held and a second byte is refused.
- R12: A threshold written above DEPTH is stored and read back as DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects single-byte mode |
| rx_valid | input | 1 | Bit engine offers a received byte this cycle |
| rx_byte | input | W | Offered byte |
| rx_ready | output | 1 | Queue has room; offered byte is stored |
| rx_nack | output | 1 | Answer the offered byte with NACK |
| scl_hold | output | 1 | Drive SCL low (stall the bus) |
| rd_en | input | 1 | Software pops the head byte |
| rd_data | output | W | Head byte of the queue |
| occupancy | output | CW | Stored byte count |
| thr_wr | input | 1 | Write threshold and LAST |
| thr_wdata | input | CW | Threshold value to write |
| last_wdata | input | 1 | LAST bit value to write |
| thr_rd | output | CW | Programmed threshold |
| last_rd | output | 1 | Programmed LAST bit |
| thr_status | output | 1 | Sticky threshold-reached flag |
| thr_status_clr | input | 1 | Write-1-to-clear for `thr_status` |
| fifo_clr | input | 1 | Empty the queue |
| rxf_flag | output | 1 | Sticky queue-full flag |
| rxf_flag_clr | input | 1 | Write-1-to-clear for `rxf_flag` |

## Verification
A stale count or pointer shows at the next clock edge as a wrong `occupancy`, or as a head byte on `rd_data` that breaks arrival order. A wrong stall decision shows one cycle later on `scl_hold`. The bench keeps a byte-exact queue model and compares every port on every cycle, so a fault appears within one or two cycles of the operation that caused it. Wrong NACK timing is checked in the same cycle the byte is offered.

// File: rtl/i2c_rxf_pkg.sv
package i2c_rxf_pkg;
   // Clamp a programmed threshold to the queue depth.
   function automatic int unsigned clamp_thr(input int unsigned v, input int unsigned lim);
      return (v > lim) ? lim : v;
   endfunction
endpackage

// File: rtl/i2c_rxf_store.sv
module i2c_rxf_store #(
   parameter int W     = 8,
   parameter int DEPTH = 32,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2 = (DEPTH == (1 << PW));

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp_nx;
         if (pop)  rp <= rp_nx;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign rdata = mem[rp];
endmodule

// File: rtl/i2c_rxf_pacer.sv
module i2c_rxf_pacer
   import i2c_rxf_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic [CW-1:0] count,
   input  logic          rx_valid,
   input  logic          push,
   input  logic          pop,
   input  logic          clr,
   input  logic          thr_wr,
   input  logic [CW-1:0] thr_wdata,
   input  logic          last_wdata,
   input  logic          thst_clr,
   input  logic          rxf_clr,
   output logic          ready,
   output logic          nack,
   output logic          hold,
   output logic [CW-1:0] thr_q,
   output logic          last_q,
   output logic          thst,
   output logic          rxf
);
   logic [CW-1:0] cap, eff_thr, cnt_nxt;
   logic [CW:0]   cnt_p1;
   logic          hold_d, thst_set, rxf_set;

   always_comb begin
      cap      = fifo_en ? CW'(DEPTH) : CW'(1);
      eff_thr  = fifo_en ? thr_q : CW'(1);
      ready    = count < cap;
      cnt_p1   = {1'b0, count} + 1'b1;
      nack     = rx_valid && last_q && (cnt_p1 == {1'b0, eff_thr});
      cnt_nxt  = clr ? '0 : count + CW'(push) - CW'(pop);
      hold_d   = (count >= cap) || (fifo_en && (thr_q != '0) && (count >= thr_q));
      thst_set = fifo_en && (thr_q != '0) && (count < thr_q) && (cnt_nxt == thr_q);
      rxf_set  = (count < cap) && (cnt_nxt >= cap);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         last_q <= 1'b0;
         hold   <= 1'b0;
         thst   <= 1'b0;
         rxf    <= 1'b0;
      end else begin
         if (thr_wr) begin
            thr_q  <= CW'(clamp_thr(int'(thr_wdata), DEPTH));
            last_q <= last_wdata;
         end
         hold <= hold_d;
         thst <= thst_set | (thst & ~thst_clr);
         rxf  <= rxf_set | (rxf & ~rxf_clr);
      end
   end
endmodule

// File: rtl/i2c_rx_fifo_ctrl.sv
module i2c_rx_fifo_ctrl #(
   parameter int W     = 8,
   parameter int DEPTH = 32,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_en,
   input  logic          rx_valid,
   input  logic [W-1:0]  rx_byte,
   output logic          rx_ready,
   output logic          rx_nack,
   output logic          scl_hold,
   input  logic          rd_en,
   output logic [W-1:0]  rd_data,
   output logic [CW-1:0] occupancy,
   input  logic          thr_wr,
   input  logic [CW-1:0] thr_wdata,
   input  logic          last_wdata,
   output logic [CW-1:0] thr_rd,
   output logic          last_rd,
   output logic          thr_status,
   input  logic          thr_status_clr,
   input  logic          fifo_clr,
   output logic          rxf_flag,
   input  logic          rxf_flag_clr
);
   generate
      if (DEPTH < 2 || W < 1 || CW < $clog2(DEPTH + 1)) begin : g_bad_cfg
         $error("i2c_rx_fifo_ctrl: illegal DEPTH/W/CW combination");
      end
   endgenerate

   logic push, pop;

   assign push = rx_valid && rx_ready;
   assign pop  = rd_en && (occupancy != '0);

   i2c_rxf_store #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fifo_clr),
      .push  (push),
      .pop   (pop),
      .wdata (rx_byte),
      .rdata (rd_data),
      .count (occupancy)
   );

   i2c_rxf_pacer #(.DEPTH(DEPTH), .CW(CW)) u_pacer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (fifo_en),
      .count      (occupancy),
      .rx_valid   (rx_valid),
      .push       (push),
      .pop        (pop),
      .clr        (fifo_clr),
      .thr_wr     (thr_wr),
      .thr_wdata  (thr_wdata),
      .last_wdata (last_wdata),
      .thst_clr   (thr_status_clr),
      .rxf_clr    (rxf_flag_clr),
      .ready      (rx_ready),
      .nack       (rx_nack),
      .hold       (scl_hold),
      .thr_q      (thr_rd),
      .last_q     (last_rd),
      .thst       (thr_status),
      .rxf        (rxf_flag)
   );
endmodule

// File: rtl/i2c_rxf_chk.sv
module i2c_rxf_chk #(
   parameter int DEPTH = 32,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fifo_en,
   input logic          rx_valid,
   input logic          rx_ready,
   input logic          rx_nack,
   input logic          scl_hold,
   input logic          rd_en,
   input logic [CW-1:0] occupancy,
   input logic [CW-1:0] thr_rd,
   input logic          fifo_clr
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= CW'(DEPTH)); // R2

   AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      ((fifo_en && occupancy == CW'(DEPTH)) || (!fifo_en && occupancy != '0)) |-> !rx_ready); // R4

   AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && occupancy != '0 && !(rx_valid && rx_ready) && !fifo_clr)
      |=> occupancy == CW'($past(occupancy) - 1'b1)); // R3

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> occupancy == '0); // R9

   AST_HOLD_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && thr_rd != '0 && occupancy >= thr_rd) |=> scl_hold); // R6

   AST_NACK_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_nack |-> rx_valid); // R8

   AST_THR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      thr_rd <= CW'(DEPTH)); // R12
endmodule

bind i2c_rx_fifo_ctrl i2c_rxf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fifo_en   (fifo_en),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .rx_nack   (rx_nack),
   .scl_hold  (scl_hold),
   .rd_en     (rd_en),
   .occupancy (occupancy),
   .thr_rd    (thr_rd),
   .fifo_clr  (fifo_clr)
);

// File: tb/tb_i2c_rx_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_rx_fifo_ctrl;
   localparam int W = 8, DEPTH = 32, CW = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic fifo_en = 1'b1, rx_valid = 1'b0, rd_en = 1'b0, thr_wr = 1'b0, last_wdata = 1'b0;
   logic thr_status_clr = 1'b0, fifo_clr = 1'b0, rxf_flag_clr = 1'b0;
   logic [W-1:0] rx_byte = '0, rd_data;
   logic [CW-1:0] thr_wdata = '0, occupancy, thr_rd;
   logic rx_ready, rx_nack, scl_hold, last_rd, thr_status, rxf_flag;

   i2c_rx_fifo_ctrl #(.W(W), .DEPTH(DEPTH), .CW(CW)) dut (.*);

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0;
   logic [7:0] q[$];
   int  thr_m = 0;
   bit  last_m = 0, fen_m = 1, hold_exp = 0, thst_m = 0, rxf_m = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int cap_f();
      return fen_m ? DEPTH : 1;
   endfunction
   function automatic bit hold_f(input int c);
      return (c >= cap_f()) || (fen_m && thr_m != 0 && c >= thr_m);
   endfunction
   function automatic bit nack_f(input int c);
      int eff = fen_m ? thr_m : 1;
      return last_m && (c + 1 == eff);
   endfunction

   // One clock cycle: drive at negedge, update model, check all ports at next negedge.
   task automatic cyc(input bit p, input logic [7:0] d, input bit r, input bit c,
                      input bit tc, input bit fc, input bit tw, input int tv, input bit lv);
      int cnt = q.size();
      int cn;
      bit acc, pp;
      rx_valid = p; rx_byte = d; rd_en = r; fifo_clr = c;
      thr_status_clr = tc; rxf_flag_clr = fc; thr_wr = tw; thr_wdata = tv[CW-1:0]; last_wdata = lv;
      #1;
      if (p) chk(rx_nack === nack_f(cnt), "R8 nack", rx_nack, nack_f(cnt));
      acc = p && (cnt < cap_f());
      pp  = r && (cnt > 0);
      hold_exp = hold_f(cnt);
      cn = c ? 0 : cnt + int'(acc) - int'(pp);
      thst_m = (fen_m && thr_m != 0 && cnt < thr_m && cn == thr_m) | (thst_m & !tc);
      rxf_m  = (cnt < cap_f() && cn >= cap_f()) | (rxf_m & !fc);
      if (c) q.delete();
      else begin
         if (pp) void'(q.pop_front());
         if (acc) q.push_back(d);
      end
      if (tw) begin
         thr_m  = (tv > DEPTH) ? DEPTH : tv;
         last_m = lv;
      end
      @(posedge clk); @(negedge clk);
      rx_valid = 0; rd_en = 0; fifo_clr = 0; thr_status_clr = 0; rxf_flag_clr = 0; thr_wr = 0;
      chk(occupancy == CW'(q.size()), "R2 occupancy", occupancy, q.size());
      if (q.size() > 0) chk(rd_data == q[0], "R2 order", rd_data, q[0]);
      chk(scl_hold == hold_exp, "R6 hold", scl_hold, hold_exp);
      chk(rx_ready == (q.size() < cap_f()), "R4 ready", rx_ready, q.size() < cap_f());
      chk(thr_status == thst_m, "R5 thst", thr_status, thst_m);
      chk(rxf_flag == rxf_m, "R10 rxf", rxf_flag, rxf_m);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic push(input logic [7:0] d);
      cyc(1, d, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic pop();
      cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic wthr(input int v, input bit l);
      cyc(0, 0, 0, 0, 0, 0, 1, v, l);
   endtask
   task automatic clear();
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(occupancy == 0, "R1 occupancy", occupancy, 0);
      chk(scl_hold == 0, "R1 hold", scl_hold, 0);
      chk(rx_ready == 1, "R1 ready", rx_ready, 1);
      chk(thr_status == 0 && rxf_flag == 0, "R1 flags", {thr_status, rxf_flag}, 0);
      chk(thr_rd == 0, "R1 thr", thr_rd, 0);

      // R12 saturation
      wthr(40, 0);
      chk(thr_rd == CW'(DEPTH), "R12 thr sat", thr_rd, DEPTH);

      // Threshold group of 4 with LAST: 4th byte NACKed, thst set, hold next cycle (R5 R6 R8)
      wthr(4, 1);
      for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
      chk(thr_status == 1, "R5 set at thr", thr_status, 1);
      chk(scl_hold == 0, "R6 hold lags one cycle", scl_hold, 0);
      idle();
      chk(scl_hold == 1, "R6 hold at thr", scl_hold, 1);
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
      chk(thr_status == 0, "R5 w1c", thr_status, 0);

      // R7 release after drain, one cycle later
      pop();
      chk(scl_hold == 1, "R7 still held first cycle", scl_hold, 1);
      idle();
      chk(scl_hold == 0, "R7 released", scl_hold, 0);
      // R7 release by raising threshold
      push(8'h55);
      idle();
      chk(scl_hold == 1, "R7 held again", scl_hold, 1);
      wthr(8, 0);
      idle();
      chk(scl_hold == 0, "R7 raise threshold release", scl_hold, 0);

      // Fill to capacity, refuse overflow (R4 R10)
      while (q.size() < DEPTH) push(8'($urandom));
      chk(rxf_flag == 1, "R10 full flag", rxf_flag, 1);
      push(8'hEE);
      chk(occupancy == CW'(DEPTH), "R4 refused", occupancy, DEPTH);
      cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);
      chk(rxf_flag == 0, "R10 w1c", rxf_flag, 0);
      for (int i = 0; i < DEPTH; i++) pop();

      // R9 clear wins over push, R3 pop on empty ignored
      push(8'h01); push(8'h02);
      cyc(1, 8'h03, 1, 1, 0, 0, 0, 0, 0);
      chk(occupancy == 0, "R9 clear", occupancy, 0);
      pop();
      chk(occupancy == 0, "R3 empty pop", occupancy, 0);
      push(8'hA5); pop();
      chk(occupancy == 0, "R3 pop decrement", occupancy, 0);

      // R11 single-byte mode
      fifo_en = 0; fen_m = 0;
      clear();
      wthr(0, 1);
      push(8'h3C);
      chk(rx_ready == 0, "R11 ready low", rx_ready, 0);
      push(8'h3D);
      chk(occupancy == 1 && rd_data == 8'h3C, "R11 second refused", occupancy, 1);
      chk(scl_hold == 1, "R11 hold", scl_hold, 1);
      pop(); idle();
      fifo_en = 1; fen_m = 1;
      clear();

      // Constrained random phases
      for (int ph = 0; ph < 6; ph++) begin
         wthr(1 + int'($urandom % DEPTH), bit'($urandom % 2));
         for (int k = 0; k < 400; k++) begin
            int s = int'($urandom % 100);
            cyc(s < 55, 8'($urandom), (s % 3) == 0, s == 99, s == 42, s == 17, 0, 0, 0);
         end
         clear();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule